// File: doc/BRIEF.md
# Three-Stage Clock Post-Divider with Phase Resynchronisation

This block divides a fast input clock by the product of three programmable ratios. The output keeps a nominal 50% duty cycle for every ratio, odd ones included. Two stages take a 4-bit select each and a third takes a 2-bit select. The stages form one mixed-radix counter, so the output period is exactly the product of the three stage ratios, measured in input clock periods.

A sync input with selectable polarity stops and restarts the output. When sync leaves its run level, the output is driven low and every stage counter is cleared. When sync returns to its run level, counting restarts from zero. The first output rise then follows the sync edge after a fixed latency, with half an input period of phase resolution. The divider also samples sync on the falling input edge and chooses between two output paths that are half a period apart. A shutdown input pauses the whole divider and forces the output low. On release, the waveform continues from where it was frozen.

Top module: `clkdiv_chain`

## Requirements
- R1: Stage ratios are decoded as follows. Stage A ratio is `sel_a_i`+1 and stage B ratio is `sel_b_i`+1, each from 1 to 16. Stage C ratio is 2 to the power `sel_c_i`, giving 1, 2, 4 or 8. The selects are changed only while the output is stopped.
- R2: While running, `clk_o` is periodic with a period of M input clock cycles, where M is the product of the three stage ratios.
- R3: In each output period, `clk_o` is high for exactly M input half-periods and low for M. This holds for odd M. For M = 1 the output copies the input clock waveform.
- R4: `sync_pol_i` = 1 makes a high sync the run level, so a falling sync edge stops the output. `sync_pol_i` = 0 makes a low sync the run level.
- R5: When the sync run level is lost at a rising input edge, `clk_o` is low from the third rising edge after that one. It stays low while sync remains away from its run level, and the stage counters are held at zero.
- R6: Let T be the first rising input edge at which sync is seen at its run level while stopped. If sync was already at its run level at the falling edge just before T, `clk_o` first rises 1.5 input periods after T. Otherwise it first rises 2 periods after T. Counting restarts from zero, so the delay from the sync edge to the first output rise lies between 2 and 2.5 input periods.
- R7: `shut_i` is registered on the rising input edge. While the registered value is 1, `clk_o` is low and all divider state is frozen. After release, the waveform resumes exactly as before, delayed by the number of shutdown cycles.
- R8: While `rst_ni` is low, `clk_o` is low and the divider is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_a_i | input | 4 | Stage A select, ratio = value + 1 |
| sel_b_i | input | 4 | Stage B select, ratio = value + 1 |
| sel_c_i | input | 2 | Stage C select, ratio = 2^value |
| sync_i | input | 1 | Stop/restart control level |
| sync_pol_i | input | 1 | Run level of sync_i (1 = high runs) |
| shut_i | input | 1 | Pause divider and force output low |
| clk_o | output | 1 | Divided, duty-corrected clock |

## Verification
The assertions assume that the three selects stay stable whenever the divider runs. They also assume that sync and polarity change only away from input clock edges, so the rising- and falling-edge samples of sync are unambiguous. The stimulus follows both assumptions. It reprograms ratios and polarity only after a stop has settled for several cycles. It moves sync either 1 ns or 6 ns after a rising edge, which covers both half-period restart paths. Shutdown windows are opened only while the divider runs with a fixed configuration.

// File: rtl/clkdiv_chain_pkg.sv
`timescale 1ns/100ps
package clkdiv_chain_pkg;

  localparam int unsigned NSTG = 3;

  // ratio of a stage decoded linearly from its select
  function automatic int unsigned lin_ratio(input int unsigned sel);
    return sel + 1;
  endfunction

  // ratio of a stage decoded as a power of two
  function automatic int unsigned pow_ratio(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  function automatic int unsigned chain_ratio(input int unsigned ra, input int unsigned rb,
                                              input int unsigned rc);
    return ra * rb * rc;
  endfunction

  // input cycles during which the rising-edge phase flag is high
  function automatic int unsigned high_cycles(input int unsigned m);
    return (m + 1) / 2;
  endfunction

  // linear position inside the output period from the mixed-radix digits
  function automatic int unsigned mixed_index(input int unsigned d0, input int unsigned d1,
                                              input int unsigned d2, input int unsigned r0,
                                              input int unsigned r1);
    return d0 + r0 * (d1 + r1 * d2);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/clkdiv_stage.sv
`timescale 1ns/100ps
module clkdiv_stage #(
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [SW-1:0] last_i,
  output logic [SW-1:0] cnt_o,
  output logic          wrap_o
);

  logic [SW-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == last_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + SW'(1);
    end
  end

endmodule

// File: rtl/clkdiv_runctl.sv
`timescale 1ns/100ps
module clkdiv_runctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic sync_i,
  input  logic pol_i,
  output logic run_o,
  output logic late_o,
  output logic start_o,
  output logic stop_o
);

  logic run_q, late_q, neg_smp_q;
  logic at_run_lvl, neg_at_run_lvl;

  // half-period sample of sync taken on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_smp_q <= 1'b0;
    else         neg_smp_q <= sync_i;
  end

  assign at_run_lvl     = (sync_i == pol_i);
  assign neg_at_run_lvl = (neg_smp_q == pol_i);

  assign start_o = !hold_i && !run_q && at_run_lvl;
  assign stop_o  = !hold_i && run_q && !at_run_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      late_q <= 1'b0;
    end else if (start_o) begin
      run_q  <= 1'b1;
      late_q <= !neg_at_run_lvl;
    end else if (stop_o) begin
      run_q  <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign late_o = late_q;

endmodule

// File: rtl/clkdiv_wave.sv
`timescale 1ns/100ps
module clkdiv_wave #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             run_i,
  input  logic             late_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic             hi_o,
  output logic             clk_o
);

  logic ph_a_q, ph_b_q, ph_c_q;
  logic is_one, is_odd, early_w, late_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_a_q <= 1'b0;
      ph_c_q <= 1'b0;
    end else if (!hold_i) begin
      ph_a_q <= run_i && (idx_i < half_i);
      ph_c_q <= ph_b_q;
    end
  end

  // half-period retimed copy for duty correction
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_b_q <= 1'b0;
    else if (!hold_i) ph_b_q <= ph_a_q;
  end

  assign is_one = (mod_i == CNT_W'(1));
  assign is_odd = mod_i[0];

  always_comb begin
    if (is_one) begin
      early_w = !clk_i && ph_b_q;
      late_w  = clk_i && ph_c_q;
    end else if (is_odd) begin
      early_w = ph_a_q && ph_b_q;
      late_w  = ph_b_q && ph_c_q;
    end else begin
      early_w = ph_b_q;
      late_w  = ph_c_q;
    end
  end

  assign clk_o = !hold_i && (late_i ? late_w : early_w);
  assign hi_o  = ph_a_q;

endmodule

// File: rtl/clkdiv_chain.sv
`timescale 1ns/100ps
module clkdiv_chain #(
  parameter int P1_W = 4,
  parameter int P2_W = 4,
  parameter int P3_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [P1_W-1:0] sel_a_i,
  input  logic [P2_W-1:0] sel_b_i,
  input  logic [P3_W-1:0] sel_c_i,
  input  logic            sync_i,
  input  logic            sync_pol_i,
  input  logic            shut_i,
  output logic            clk_o
);
  import clkdiv_chain_pkg::*;

  localparam int R_A_MAX = 1 << P1_W;
  localparam int R_B_MAX = 1 << P2_W;
  localparam int R_C_MAX = 1 << ((1 << P3_W) - 1);
  localparam int R_MAX   = max3(R_A_MAX, R_B_MAX, R_C_MAX);
  localparam int SW      = $clog2(R_MAX);
  localparam int MOD_W   = SW + 1;
  localparam int SELW    = max3(P1_W, P2_W, P3_W);
  localparam int CNT_W   = $clog2(R_A_MAX * R_B_MAX * R_C_MAX) + 1;
  localparam int CFG_W   = P1_W + P2_W + P3_W;

  logic                  shut_q;
  logic                  run_q, late_q, start_evt, stop_evt, hi_phase;
  logic [SELW-1:0]       sel_pack [NSTG];
  logic [MOD_W-1:0]      ratio    [NSTG];
  logic [SW-1:0]         last     [NSTG];
  logic [SW-1:0]         digit    [NSTG];
  logic [NSTG-1:0]       step, wrap;
  logic [CNT_W-1:0]      idx, mod_total, half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shut_q <= 1'b0;
    else         shut_q <= shut_i;
  end

  assign sel_pack[0] = SELW'(sel_a_i);
  assign sel_pack[1] = SELW'(sel_b_i);
  assign sel_pack[2] = SELW'(sel_c_i);

  clkdiv_runctl u_runctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (shut_q),
    .sync_i  (sync_i),
    .pol_i   (sync_pol_i),
    .run_o   (run_q),
    .late_o  (late_q),
    .start_o (start_evt),
    .stop_o  (stop_evt)
  );

  assign step[0] = run_q && !shut_q;

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    if (i == NSTG - 1) begin : g_pow
      assign ratio[i] = MOD_W'(pow_ratio(32'(sel_pack[i])));
    end else begin : g_lin
      assign ratio[i] = MOD_W'(lin_ratio(32'(sel_pack[i])));
    end
    assign last[i] = SW'(ratio[i] - MOD_W'(1));
    if (i > 0) begin : g_carry
      assign step[i] = wrap[i-1];
    end
    clkdiv_stage #(.SW(SW)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!run_q),
      .step_i (step[i]),
      .last_i (last[i]),
      .cnt_o  (digit[i]),
      .wrap_o (wrap[i])
    );
  end

  assign mod_total = CNT_W'(chain_ratio(32'(ratio[0]), 32'(ratio[1]), 32'(ratio[2])));
  assign half      = CNT_W'(high_cycles(32'(mod_total)));
  assign idx       = CNT_W'(mixed_index(32'(digit[0]), 32'(digit[1]), 32'(digit[2]),
                                        32'(ratio[0]), 32'(ratio[1])));

  clkdiv_wave #(.CNT_W(CNT_W)) u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (shut_q),
    .run_i  (run_q),
    .late_i (late_q),
    .idx_i  (idx),
    .half_i (half),
    .mod_i  (mod_total),
    .hi_o   (hi_phase),
    .clk_o  (clk_o)
  );

endmodule

// File: rtl/clkdiv_chain_chk.sv
`timescale 1ns/100ps
module clkdiv_chain_chk #(
  parameter int CNT_W = 12,
  parameter int CFG_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_q,
  input logic             shut_q,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             hi_phase,
  input logic [CNT_W-1:0] idx,
  input logic [CNT_W-1:0] mod_total,
  input logic [CFG_W-1:0] cfg,
  input logic             clk_o
);

  logic [1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         idle_cnt <= 2'd0;
    else if (run_q)                      idle_cnt <= 2'd0;
    else if (idle_cnt != 2'd3)           idle_cnt <= idle_cnt + 2'd1;
  end

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> $stable(cfg)) else $error("select changed while running"); // R1

  AST_IDX_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx < mod_total) else $error("position beyond period"); // R2

  AST_HIGH_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !shut_q && idle_cnt != 2'd0) |=> !hi_phase) else $error("phase flag set while stopped"); // R3

  AST_STOP_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !run_q) else $error("stop event ignored"); // R5

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !shut_q && idle_cnt == 2'd3) |-> !clk_o) else $error("output active while stopped"); // R5

  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> run_q) else $error("start event ignored"); // R6

  AST_START_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> idx == '0) else $error("restart not from zero"); // R6

  AST_FROZEN_IN_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_q |=> ($stable(idx) && $stable(run_q))) else $error("state moved during shutdown"); // R7

endmodule

bind clkdiv_chain clkdiv_chain_chk #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_q     (run_q),
  .shut_q    (shut_q),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .hi_phase  (hi_phase),
  .idx       (idx),
  .mod_total (mod_total),
  .cfg       ({sel_a_i, sel_b_i, sel_c_i}),
  .clk_o     (clk_o)
);

// File: tb/clkdiv_chain_tb_top.sv
`timescale 1ns/100ps
module clkdiv_chain_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sa = '0, sb = '0;
  logic [1:0] sc = '0;
  logic       sync = 1'b0, pol = 1'b1, shut = 1'b0;
  logic       clk_out;

  int checks = 0, fails = 0, kpos = 0;
  int m_run = 0, m_s = 0, m_m = 1, m_mask = 0, m_lo = 0, m_hi = 0, m_shift = 0;
  bit m_rst = 1'b1, m_pol0 = 1'b0, done = 1'b0;

  clkdiv_chain dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sel_a_i    (sa),
    .sel_b_i    (sb),
    .sel_c_i    (sc),
    .sync_i     (sync),
    .sync_pol_i (pol),
    .shut_i     (shut),
    .clk_o      (clk_out)
  );

  always #5 clk = ~clk;

  // R1: ratio from the select fields
  function automatic int ref_ratio(int a, int b, int c);
    return (a + 1) * (b + 1) * (1 << c);
  endfunction

  task automatic sample(int hs);
    bit    expv;
    string tag;
    int    s_eff;
    if (done || hs < m_mask) return;
    if (m_rst) begin
      expv = 1'b0; tag = "R8";
    end else if (m_hi > m_lo && hs >= m_lo && hs < m_hi) begin
      expv = 1'b0; tag = "R7";
    end else if (m_run == 0) begin
      expv = 1'b0; tag = "R5";
    end else begin
      s_eff = m_s + ((m_hi > m_lo && hs >= m_hi) ? m_shift : 0);
      if (hs < s_eff) begin
        expv = 1'b0; tag = "R6";
      end else begin
        expv = ((hs - s_eff) % (2 * m_m)) < m_m;
        if (hs < s_eff + 2 * m_m)              tag = "R6";
        else if (m_hi > m_lo && hs >= m_hi)    tag = "R7";
        else if (m_pol0)                       tag = "R4";
        else                                   tag = "R1 R2 R3";
      end
    end
    checks++;
    if (clk_out !== expv) begin
      fails++;
      $display("FAIL %s half-slot=%0d M=%0d actual=%b expected=%b", tag, hs, m_m, clk_out, expv);
    end
  endtask

  // samples each half period away from both clock edges
  always begin
    @(posedge clk);
    kpos++;
    #2.5;
    sample(2 * kpos);
    #5;
    sample(2 * kpos + 1);
  end

  task automatic settle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic configure(int a, int b, int c, bit p);
    @(posedge clk); #1;
    sa = 4'(a); sb = 4'(b); sc = 2'(c);
    pol = p; sync = ~p;
    m_pol0 = ~p;
    m_m = ref_ratio(a, b, c);
  endtask

  task automatic start_run(bit late);
    int k;
    @(posedge clk); #1;
    k = kpos;
    m_lo = 0; m_hi = 0; m_shift = 0;
    m_s = 2 * k + 5 + int'(late);   // R6 latency from the sync edge
    m_run = 1;
    if (late) #5;
    sync = pol;
  endtask

  task automatic stop_run();
    int k;
    @(posedge clk); #1;
    k = kpos;
    m_mask = 2 * k + 7;             // R5 output low from here on
    m_run = 0;
    sync = ~pol;
  endtask

  task automatic shut_for(int d);
    int k;
    @(posedge clk); #1;
    k = kpos;
    m_lo = 2 * k + 2;               // R7 forced low once registered
    m_hi = 2 * (k + d + 1);
    m_shift = 2 * d;
    shut = 1'b1;
    repeat (d) @(posedge clk);
    #1;
    shut = 1'b0;
  endtask

  task automatic run_one(int a, int b, int c, bit p, bit late, bit with_shut);
    configure(a, b, c, p);
    settle(4);
    start_run(late);
    settle(2 * m_m + 6);
    if (with_shut) begin
      shut_for(3 + (m_m % 4));
      settle(2 * m_m + 4);
    end
    stop_run();
    settle(6);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    settle(5);                      // R8 reset state checked by the sampler
    #1;
    rst_n = 1'b1;
    m_rst = 1'b0;
    settle(4);
    run_one(0, 0, 0, 1'b1, 1'b0, 1'b0);   // M=1 follows input clock (R3)
    run_one(0, 0, 0, 1'b1, 1'b1, 1'b1);
    run_one(1, 0, 0, 1'b1, 1'b0, 1'b0);
    run_one(2, 0, 0, 1'b1, 1'b1, 1'b0);   // odd ratio
    run_one(2, 2, 0, 1'b1, 1'b0, 1'b1);
    run_one(4, 2, 1, 1'b1, 1'b1, 1'b1);
    run_one(0, 0, 3, 1'b1, 1'b0, 1'b0);   // stage C only
    run_one(15, 15, 3, 1'b1, 1'b0, 1'b0); // largest ratio
    run_one(2, 1, 1, 1'b0, 1'b1, 1'b0);   // R4 low run level
    run_one(6, 0, 0, 1'b0, 1'b0, 1'b1);   // R4 odd, with shutdown
    for (int i = 0; i < 8; i++) begin
      run_one(int'($urandom % 16), int'($urandom % 16), int'($urandom % 4),
              1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule